// File: doc/BRIEF.md
# Configurable Pixel-to-Word Packer

This block sits between a video converter and a frame buffer write port. It takes one digitized sample per clock when its strobe is high. It collects the samples into 32-bit words and hands each finished word on with a one-clock strobe. A mode input sets how samples are laid out. In narrow mode, four 8-bit pixels fill a word. In wide mode, two 10-bit pixels fill a word, each in its own 16-bit half. In reduced mode, each 10-bit sample drops its two lowest bits and then packs four per word, as in narrow mode. The first pixel of a word always takes the lowest lane.

The mode is read only at a word boundary, so one word never mixes layouts. A flush input closes a partly filled word, for example at the start of a line. The lanes that were not filled are driven to zero. A running count of emitted words is kept beside the data.

Top module: `pix_packer`

## Requirements
- R1: With mode code 0, four accepted pixels form one word. The k-th pixel of the word (k = 0..3) takes bits 8k+7:8k from `pix_data_i[7:0]`, and `pix_data_i[9:8]` are ignored.
- R2: With mode code 1, two accepted pixels form one word. The first pixel's 10 bits are placed at bits 9:0 and the second pixel's at bits 25:16.
- R3: With mode code 1, bits 15:10 and 31:26 of every emitted word are zero.
- R4: With mode code 2, each sample contributes `pix_data_i[9:2]` and is packed in the R1 lane order. Code 3 behaves exactly as code 0.
- R5: `word_valid_o` is high for exactly one clock per emitted word. That clock is the cycle after the clock edge that accepted the word's last pixel or its flush. `word_data_o` holds the word in that cycle.
- R6: `mode_i` is sampled only in a cycle where the current word holds no pixel. A change while a word is partly filled does not affect that word.
- R7: A flush while the word holds pixels emits it with the unfilled lanes zero. If a pixel is offered in the same cycle, it is included first. The next pixel then starts at the lowest lane.
- R8: A flush with an empty word and no pixel produces no output.
- R9: `word_count_o` rises by one with each emitted word and is updated in the same cycle that `word_valid_o` is high. It wraps to zero after its all-ones value and otherwise holds.
- R10: After reset, `word_valid_o` is low, `word_count_o` is zero and the first pixel goes to the lowest lane.
- R11: Samples offered with `pix_valid_i` low are not packed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Layout select: 0 narrow, 1 wide, 2 reduced, 3 as 0 |
| pix_valid_i | input | 1 | Sample strobe |
| pix_data_i | input | PIX_W | Converter sample |
| flush_i | input | 1 | Close the current partial word |
| word_valid_o | output | 1 | One-clock strobe for a finished word |
| word_data_o | output | WORD_W | Packed word |
| word_count_o | output | CNT_W | Count of emitted words, wrapping |

## Verification
Each word, and the count that goes with it, is due one clock after the edge that takes the word's last pixel or its flush. Every other cycle must show the strobe low. The bench drives inputs 2 ns after a rising edge and reads the outputs at that same point after the next edge. Its reference model is stepped once per edge, so each expected strobe, word and count is compared in exactly the cycle it belongs to. Cycles where nothing should come out are checked in the same way. Fixed words check the lane order against literal values. Long random streams in all modes, with mode changes and flushes placed mid-word, check the zero fill and the boundary rule for mode.

// File: rtl/pix_pack_pkg.sv
// Shared types for the pixel packer.
package pix_pack_pkg;
    // Layout codes seen on mode_i; code 3 is treated as narrow.
    typedef enum logic [1:0] {
        PK_MODE_8     = 2'd0,
        PK_MODE_10    = 2'd1,
        PK_MODE_10TO8 = 2'd2,
        PK_MODE_ALT8  = 2'd3
    } pk_mode_e;
endpackage

// File: rtl/pix_pack_lane_fmt.sv
// Lane formatter: places one sample into its lane of an otherwise
// zero word, according to the layout mode.
// Assumes lane_i is below the lane count of the selected layout.
module pix_pack_lane_fmt
    import pix_pack_pkg::*;
#(
    parameter int PIX_W    = 10,
    parameter int NARROW_W = 8,
    parameter int WORD_W   = 32,
    parameter int LANE_W   = 2
) (
    input  pk_mode_e            mode_i,
    input  logic [LANE_W-1:0]   lane_i,
    input  logic [PIX_W-1:0]    pix_i,
    output logic [WORD_W-1:0]   placed_o
);
    localparam int NARROW_LANES = WORD_W / NARROW_W;
    localparam int WIDE_SLOT    = WORD_W / 2;
    localparam int WIDE_LANES   = 2;

    logic [NARROW_W-1:0] narrow_val;
    logic [WORD_W-1:0]   narrow_word;
    logic [WORD_W-1:0]   wide_word;

    // Pick the 8-bit value: low bits, or the sample shifted down.
    always_comb begin
        if (mode_i == PK_MODE_10TO8)
            narrow_val = pix_i[PIX_W-1 -: NARROW_W];
        else
            narrow_val = pix_i[NARROW_W-1:0];
    end

    for (genvar i = 0; i < NARROW_LANES; i++) begin : g_narrow
        assign narrow_word[i*NARROW_W +: NARROW_W] =
            (lane_i == LANE_W'(i)) ? narrow_val : '0;
    end

    for (genvar j = 0; j < WIDE_LANES; j++) begin : g_wide
        assign wide_word[j*WIDE_SLOT +: WIDE_SLOT] =
            (lane_i == LANE_W'(j)) ? WIDE_SLOT'(pix_i) : '0;
    end

    // Select the layout for the word being built.
    always_comb begin
        placed_o = (mode_i == PK_MODE_10) ? wide_word : narrow_word;
    end
endmodule

// File: rtl/pix_pack_assembler.sv
// Word assembler: ORs placed lanes into an accumulator, tracks the
// lane index and emits a one-clock strobe with the finished word.
// Assumes placed_i has only the lane of lane_o set.
module pix_pack_assembler #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid_i,
    input  logic              flush_i,
    input  logic [LANE_W-1:0] last_lane_i,
    input  logic [WORD_W-1:0] placed_i,
    output logic [LANE_W-1:0] lane_o,
    output logic              word_valid_o,
    output logic [WORD_W-1:0] word_data_o,
    output logic              emit_o
);
    logic [LANE_W-1:0] lane_q;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] merged;
    logic              word_valid_q;
    logic [WORD_W-1:0] word_q;
    logic              take_full;
    logic              take_flush;

    // Merge the new lane into the word; a fresh word starts from zero.
    always_comb begin
        base       = (lane_q == '0) ? '0 : acc_q;
        merged     = base | placed_i;
        take_full  = pix_valid_i && (lane_q == last_lane_i);
        take_flush = flush_i && (pix_valid_i || (lane_q != '0));
        emit_o     = take_full || take_flush;
    end

    // Advance the lane, hold the partial word and register the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q       <= '0;
            acc_q        <= '0;
            word_valid_q <= 1'b0;
            word_q       <= '0;
        end else begin
            word_valid_q <= emit_o;
            if (emit_o) begin
                word_q <= pix_valid_i ? merged : acc_q;
                lane_q <= '0;
            end else if (pix_valid_i) begin
                acc_q  <= merged;
                lane_q <= lane_q + 1'b1;
            end
        end
    end

    assign lane_o       = lane_q;
    assign word_valid_o = word_valid_q;
    assign word_data_o  = word_q;

    AST_LANE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> (lane_q == '0)); // R7
endmodule

// File: rtl/pix_pack_wcount.sv
// Emitted-word counter; wraps at its width.
module pix_pack_wcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count one per emitted word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (inc_i)
            cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/pix_packer.sv
// Pixel-to-word packer top. Latches the layout mode at word
// boundaries, formats each sample into its lane, assembles words and
// counts them. Assumes one sample at most per clock.
module pix_packer
    import pix_pack_pkg::*;
#(
    parameter int PIX_W    = 10,
    parameter int NARROW_W = 8,
    parameter int WORD_W   = 32,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              pix_valid_i,
    input  logic [PIX_W-1:0]  pix_data_i,
    input  logic              flush_i,
    output logic              word_valid_o,
    output logic [WORD_W-1:0] word_data_o,
    output logic [CNT_W-1:0]  word_count_o
);
    localparam int NARROW_LANES = WORD_W / NARROW_W;
    localparam int WIDE_LANES   = 2;
    localparam int LANE_W       = $clog2(NARROW_LANES);
    localparam int WIDE_SLOT    = WORD_W / 2;

    pk_mode_e          mode_q;
    pk_mode_e          eff_mode;
    logic [LANE_W-1:0] lane_q;
    logic [LANE_W-1:0] last_lane;
    logic [WORD_W-1:0] placed;
    logic              emit;

    // Take a new mode only while the word is empty.
    always_comb begin
        eff_mode  = (lane_q == '0) ? pk_mode_e'(mode_i) : mode_q;
        last_lane = (eff_mode == PK_MODE_10) ? LANE_W'(WIDE_LANES - 1)
                                             : LANE_W'(NARROW_LANES - 1);
    end

    // Hold the mode of the word in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= PK_MODE_8;
        else
            mode_q <= eff_mode;
    end

    pix_pack_lane_fmt #(
        .PIX_W(PIX_W), .NARROW_W(NARROW_W), .WORD_W(WORD_W), .LANE_W(LANE_W)
    ) u_fmt (
        .mode_i  (eff_mode),
        .lane_i  (lane_q),
        .pix_i   (pix_data_i),
        .placed_o(placed)
    );

    pix_pack_assembler #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid_i (pix_valid_i),
        .flush_i     (flush_i),
        .last_lane_i (last_lane),
        .placed_i    (placed),
        .lane_o      (lane_q),
        .word_valid_o(word_valid_o),
        .word_data_o (word_data_o),
        .emit_o      (emit)
    );

    pix_pack_wcount #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (emit),
        .count_o(word_count_o)
    );

    AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> $past(pix_valid_i || flush_i)); // R5
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_o && $past(eff_mode) == PK_MODE_10) |->
        (word_data_o[WIDE_SLOT-1:PIX_W] == '0 &&
         word_data_o[WORD_W-1:WIDE_SLOT+PIX_W] == '0)); // R3
    AST_IDLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && !pix_valid_i && lane_q == '0) |=> !word_valid_o); // R8
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> (word_count_o == $past(word_count_o) + 1'b1)); // R9
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid_o |-> $stable(word_count_o)); // R9
endmodule

// File: tb/pix_packer_bench.sv
module pix_packer_bench;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       mode_i;
    logic             pix_valid_i;
    logic [9:0]       pix_data_i;
    logic             flush_i;
    logic             word_valid_o;
    logic [31:0]      word_data_o;
    logic [CNT_W-1:0] word_count_o;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int               m_lane;
    logic [31:0]      m_acc;
    logic [1:0]       m_mode;
    logic [CNT_W-1:0] m_cnt;

    always #4 clk = ~clk;

    pix_packer #(.CNT_W(CNT_W)) u_pix_packer (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .pix_valid_i(pix_valid_i),
        .pix_data_i(pix_data_i), .flush_i(flush_i), .word_valid_o(word_valid_o),
        .word_data_o(word_data_o), .word_count_o(word_count_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive, advance model, compare after the edge.
    task automatic step(input logic v, input logic [9:0] p, input logic f,
                        input logic [1:0] m, input string req);
        logic [1:0]  eff;
        int          lanes;
        logic [31:0] val;
        logic        exp_v;
        logic [31:0] exp_w;
        pix_valid_i = v; pix_data_i = p; flush_i = f; mode_i = m;
        eff   = (m_lane == 0) ? m : m_mode;
        lanes = (eff == 2'd1) ? 2 : 4;
        exp_v = 1'b0; exp_w = '0;
        if (v) begin
            if (eff == 2'd1) val = {22'd0, p} << (16 * m_lane);
            else if (eff == 2'd2) val = {24'd0, p[9:2]} << (8 * m_lane);
            else val = {24'd0, p[7:0]} << (8 * m_lane);
            if (m_lane == 0) m_acc = '0;
            m_acc  = m_acc | val;
            m_lane = m_lane + 1;
        end
        if ((v && m_lane == lanes) || (f && m_lane != 0)) begin
            exp_v = 1'b1; exp_w = m_acc; m_cnt = m_cnt + 1'b1; m_lane = 0;
        end
        m_mode = eff;
        @(posedge clk); #2;
        check(req, {31'd0, word_valid_o}, {31'd0, exp_v});
        if (exp_v) begin
            check(req, word_data_o, exp_w);
            check("R9", {24'd0, word_count_o}, {24'd0, m_cnt});
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pix_valid_i = 0; pix_data_i = 0; flush_i = 0; mode_i = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        m_lane = 0; m_acc = '0; m_mode = 0; m_cnt = '0;
        check("R10", {31'd0, word_valid_o}, 32'd0);
        check("R10", {24'd0, word_count_o}, 32'd0);
    endtask

    task automatic t_r1_narrow();
        step(1, 10'h311, 0, 0, "R1"); step(1, 10'h222, 0, 0, "R1");
        step(1, 10'h133, 0, 0, "R1"); step(1, 10'h044, 0, 0, "R1");
        check("R1", word_data_o, 32'h44332211);
        step(0, 0, 0, 0, "R5");
    endtask

    task automatic t_r2_wide();
        step(1, 10'h3AA, 0, 1, "R2"); step(1, 10'h155, 0, 1, "R2");
        check("R2", word_data_o, 32'h015503AA);
        step(1, 10'h3FF, 0, 1, "R3"); step(1, 10'h3FF, 0, 1, "R3");
        check("R3", word_data_o & 32'hFC00FC00, 32'h0);
    endtask

    task automatic t_r4_reduced();
        step(1, 10'h3FC, 0, 2, "R4"); step(1, 10'h004, 0, 2, "R4");
        step(1, 10'h100, 0, 2, "R4"); step(1, 10'h2AA, 0, 2, "R4");
        check("R4", word_data_o, 32'hAA4001FF);
        for (int i = 0; i < 4; i++) step(1, 10'(i * 71 + 5), 0, 3, "R4");
    endtask

    task automatic t_r6_mode_change();
        step(1, 10'h0AB, 0, 0, "R6");
        step(1, 10'h0CD, 0, 1, "R6");
        step(1, 10'h0EF, 0, 2, "R6");
        step(1, 10'h012, 0, 1, "R6");
        check("R6", word_data_o, 32'h12EFCDAB);
        step(1, 10'h201, 0, 1, "R6"); step(1, 10'h102, 0, 1, "R6");
    endtask

    task automatic t_r7_flush();
        step(1, 10'h0A1, 0, 0, "R7");
        step(0, 0, 1, 0, "R7");
        check("R7", word_data_o, 32'h000000A1);
        step(1, 10'h0B2, 0, 0, "R7");
        step(1, 10'h0C3, 1, 0, "R7");
        check("R7", word_data_o, 32'h0000C3B2);
        step(1, 10'h2D4, 1, 1, "R7");
        check("R7", word_data_o, 32'h000002D4);
    endtask

    task automatic t_r8_idle_flush();
        step(0, 0, 1, 0, "R8"); step(0, 0, 1, 1, "R8"); step(0, 0, 0, 0, "R8");
    endtask

    task automatic t_r11_gaps();
        step(1, 10'h011, 0, 0, "R11"); step(0, 10'h0EE, 0, 0, "R11");
        step(1, 10'h022, 0, 0, "R11"); step(0, 10'h0DD, 0, 0, "R11");
        step(1, 10'h033, 0, 0, "R11"); step(1, 10'h044, 0, 0, "R11");
        check("R11", word_data_o, 32'h44332211);
    endtask

    task automatic t_random();
        for (int i = 0; i < 3000; i++)
            step(($urandom % 4) != 0, 10'($urandom), ($urandom % 9) == 0,
                 2'($urandom % 4), "R5");
    endtask

    task automatic t_r9_wrap();
        for (int i = 0; i < 300; i++) step(1, 10'(i), 1, 1, "R9");
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_r1_narrow();
        t_r2_wide();
        t_r4_reduced();
        t_r6_mode_change();
        t_r7_flush();
        t_r8_idle_flush();
        t_r11_gaps();
        t_random();
        t_r9_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule